// File: doc/BRIEF.md
# Width-Converting Parity FIFO for DMA

This block is a sixteen-byte first-in first-out store between a 16-bit DMA word port and an 8-bit byte port. A direction input picks the flow. With `dir` low, words arrive from DMA and leave as bytes. With `dir` high, bytes arrive and leave as DMA words. In both cases the byte in bits 7:0 of a word is the earlier byte in the byte stream.

Every stored byte keeps its own parity bit. In check mode, the block tests incoming parity and stores freshly generated odd parity. In pass-through mode, it keeps the supplied parity bits untouched. A DMA request output follows the fill level, with either a burst threshold of eight bytes or a single-word threshold. A drain input lets the DMA side empty the store after an aborted transfer, including a final odd byte returned as a marked partial word.

Top module: `dma_width_fifo`

## Requirements
- R1: The store holds at most 16 bytes. `count` reports the number of stored bytes, from 0 to 16, and is 0 after reset.
- R2: With `dir`=0, an accepted `dma_wr` stores `dma_wdata[7:0]` before `dma_wdata[15:8]`. `byte_rdata` always shows the oldest byte, and an accepted `byte_rd` removes it.
- R3: With `dir`=1, an accepted `byte_wr` stores one byte. `dma_rdata` shows the oldest byte in bits 7:0 and the next byte in bits 15:8, and an accepted `dma_rd` removes both.
- R4: With `par_chk`=1, parity is odd: a byte's bit plus its eight data bits hold an odd number of ones. Output parity is generated this way. An accepted write whose supplied parity is wrong sets `par_err`, which stays set until `status_clr` is asserted. Each DMA lane `i` carries the parity of byte `i`.
- R5: With `par_chk`=0, supplied parity bits are stored and returned unchanged, and `par_err` is never set.
- R6: With `burst`=1, `dma_req` is high for `dir`=0 when at least 8 bytes are free, and for `dir`=1 when at least 8 bytes are stored.
- R7: With `burst`=0, `dma_req` is high for `dir`=0 when at least 2 bytes are free, and for `dir`=1 when at least 2 bytes are stored.
- R8: While `drain`=1, `dma_rd` is accepted in either direction and `byte_rd` is ignored. When exactly one byte remains, `dma_rdata` is that byte in bits 7:0 with bits 15:8 zero, `dma_rpar[1]` is 1, and `dma_partial` is 1. A `dma_rd` then empties the store.
- R9: A write for which there is no room is ignored, and it sets the sticky flag `ovf`.
- R10: A read with too few bytes stored is ignored, and it sets the sticky flag `unf`. Without drain, a word read needs 2 bytes.
- R11: `flush` empties the store at the next clock edge and overrides every strobe in that cycle.
- R12: Without drain, `byte_wr` and `dma_rd` are ignored when `dir`=0, and `dma_wr` and `byte_rd` are ignored when `dir`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir | input | 1 | 0: DMA to byte port, 1: byte port to DMA |
| burst | input | 1 | Selects the eight-byte request threshold |
| par_chk | input | 1 | 1: generate and check parity, 0: pass parity through |
| drain | input | 1 | Residue readout by the DMA side |
| flush | input | 1 | Synchronous empty |
| status_clr | input | 1 | Clears par_err, ovf and unf |
| dma_wr | input | 1 | Word write strobe |
| dma_wdata | input | 16 | Word to store |
| dma_wpar | input | 2 | Parity of each lane of dma_wdata |
| dma_rd | input | 1 | Word read strobe |
| dma_rdata | output | 16 | Oldest word |
| dma_rpar | output | 2 | Parity of each lane of dma_rdata |
| dma_partial | output | 1 | dma_rdata holds a single residual byte |
| dma_req | output | 1 | DMA request |
| byte_wr | input | 1 | Byte write strobe |
| byte_wdata | input | 8 | Byte to store |
| byte_wpar | input | 1 | Parity of byte_wdata |
| byte_rd | input | 1 | Byte read strobe |
| byte_rdata | output | 8 | Oldest byte |
| byte_rpar | output | 1 | Parity of byte_rdata |
| count | output | 5 | Stored byte count |
| par_err | output | 1 | Sticky parity error |
| ovf | output | 1 | Sticky overflow |
| unf | output | 1 | Sticky underflow |

## Verification
A wrong byte count shows up at once on `count`, and in the same cycle it moves `dma_req` across its thresholds. A misplaced read or write pointer shows up on the read data of the very next read. This shows as swapped lanes, a repeated byte or a skipped byte, and the full sweep of byte values exposes it. A parity bit lost in storage, or a flag that fails to stick, shows up on the first read or the first cycle after the offending strobe.

// File: rtl/dma_width_fifo.sv
module dma_width_fifo #(
  parameter int AW  = 4,
  parameter int THR = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dir,
  input  logic        burst,
  input  logic        par_chk,
  input  logic        drain,
  input  logic        flush,
  input  logic        status_clr,
  input  logic        dma_wr,
  input  logic [15:0] dma_wdata,
  input  logic [1:0]  dma_wpar,
  input  logic        dma_rd,
  output logic [15:0] dma_rdata,
  output logic [1:0]  dma_rpar,
  output logic        dma_partial,
  output logic        dma_req,
  input  logic        byte_wr,
  input  logic [7:0]  byte_wdata,
  input  logic        byte_wpar,
  input  logic        byte_rd,
  output logic [7:0]  byte_rdata,
  output logic        byte_rpar,
  output logic [AW:0] count,
  output logic        par_err,
  output logic        ovf,
  output logic        unf
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = AW + 1;

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [8:0]    lo_e, hi_e;

  wire w_word = ~dir & dma_wr;
  wire w_byte = dir & byte_wr;
  wire r_word = dma_rd & (dir | drain);
  wire r_byte = byte_rd & ~dir & ~drain;

  wire ok_ww = w_word & (count <= CW'(DEPTH - 2));
  wire ok_wb = w_byte & (count < CW'(DEPTH));
  wire ok_rw = r_word & ((count >= CW'(2)) | (drain & (count == CW'(1))));
  wire ok_rb = r_byte & (count != '0);

  wire gp_lo = ~^dma_wdata[7:0];
  wire gp_hi = ~^dma_wdata[15:8];
  wire gp_b  = ~^byte_wdata;
  wire p_lo  = par_chk ? gp_lo : dma_wpar[0];
  wire p_hi  = par_chk ? gp_hi : dma_wpar[1];
  wire p_b   = par_chk ? gp_b : byte_wpar;

  wire bad_par = par_chk & ((ok_ww & ((dma_wpar[0] != gp_lo) | (dma_wpar[1] != gp_hi)))
                          | (ok_wb & (byte_wpar != gp_b)));

  wire [1:0] wsz = ok_ww ? 2'd2 : (ok_wb ? 2'd1 : 2'd0);
  wire [1:0] rsz = ok_rw ? ((count >= CW'(2)) ? 2'd2 : 2'd1) : (ok_rb ? 2'd1 : 2'd0);

  assign lo_e = mem[rp];
  assign hi_e = mem[rp + AW'(1)];

  assign dma_partial = drain & (count == CW'(1));
  assign dma_rdata   = dma_partial ? {8'h00, lo_e[7:0]} : {hi_e[7:0], lo_e[7:0]};
  assign dma_rpar    = dma_partial ? {1'b1, lo_e[8]} : {hi_e[8], lo_e[8]};
  assign byte_rdata  = lo_e[7:0];
  assign byte_rpar   = lo_e[8];

  assign dma_req = dir ? (burst ? (count >= CW'(THR)) : (count >= CW'(2)))
                       : (burst ? (count <= CW'(DEPTH - THR)) : (count <= CW'(DEPTH - 2)));

  always_ff @(posedge clk) begin
    if (!flush) begin
      if (ok_ww) begin
        mem[wp]          <= {p_lo, dma_wdata[7:0]};
        mem[wp + AW'(1)] <= {p_hi, dma_wdata[15:8]};
      end else if (ok_wb) begin
        mem[wp] <= {p_b, byte_wdata};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
      par_err <= 1'b0; ovf <= 1'b0; unf <= 1'b0;
    end else begin
      if (flush) begin
        wp <= '0; rp <= '0; count <= '0;
      end else begin
        wp    <= wp + AW'(wsz);
        rp    <= rp + AW'(rsz);
        count <= count + CW'(wsz) - CW'(rsz);
      end
      par_err <= (par_err & ~status_clr) | (~flush & bad_par);
      ovf     <= (ovf & ~status_clr) | (~flush & ((w_word & ~ok_ww) | (w_byte & ~ok_wb)));
      unf     <= (unf & ~status_clr) | (~flush & ((r_word & ~ok_rw) | (r_byte & ~ok_rb)));
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R11
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  // R9
  full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && w_word && count == CW'(DEPTH)) |=> (ovf && count <= CW'(DEPTH)));

  // R10
  empty_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && r_byte && count == '0) |=> unf);

  // R4
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !status_clr) |=> par_err);

  // R5
  pass_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_chk && !par_err && !status_clr) |=> !par_err);

  // R8
  drain_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_partial && dma_rd && !flush && !dir && !dma_wr) |=> (count == '0));
endmodule

// File: tb/sim_dma_width_fifo.sv
module sim_dma_width_fifo;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic dir = 0, burst = 0, par_chk = 1, drain = 0, flush = 0, status_clr = 0;
  logic dma_wr = 0, dma_rd = 0, byte_wr = 0, byte_rd = 0, byte_wpar = 0;
  logic [15:0] dma_wdata = 0;
  logic [1:0]  dma_wpar = 0;
  logic [7:0]  byte_wdata = 0;
  logic [15:0] dma_rdata;
  logic [1:0]  dma_rpar;
  logic dma_partial, dma_req, byte_rpar, par_err, ovf, unf;
  logic [7:0] byte_rdata;
  logic [4:0] count;

  int checks = 0, fails = 0;

  dma_width_fifo u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic op(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    dma_wr = 0; dma_rd = 0; byte_wr = 0; byte_rd = 0; flush = 0; status_clr = 0;
  endtask

  task automatic put_word(input logic [15:0] w, input logic [1:0] p);
    dma_wdata = w; dma_wpar = p; dma_wr = 1; tick();
  endtask

  task automatic put_byte(input logic [7:0] b, input logic p);
    byte_wdata = b; byte_wpar = p; byte_wr = 1; tick();
  endtask

  task automatic clr();
    status_clr = 1; tick();
  endtask

  function automatic int exp_req(input int c, input logic d, input logic b);
    if (d) return b ? int'(c >= 8) : int'(c >= 2);
    return b ? int'(16 - c >= 8) : int'(16 - c >= 2);
  endfunction

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 3); rst_n = 1; #1;
    @(negedge clk);
    // R1 reset state
    chk(count == 0 && !par_err && !ovf && !unf, "R1", count, 0);

    // R2, R4, R9: fill with words, then read back bytes
    dir = 0; par_chk = 1;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] lo, hi;
      lo = 8'(i * 17); hi = 8'(255 - i * 3);
      put_word({hi, lo}, {op(hi), op(lo)});
      chk(count == 5'(2 * (i + 1)), "R1", count, 2 * (i + 1));
    end
    put_word(16'hBEEF, {op(8'hBE), op(8'hEF)});
    chk(count == 16 && ovf, "R9", {ovf, count}, {1'b1, 5'd16});
    chk(!par_err, "R4", par_err, 0);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] e;
      e = (i % 2 == 0) ? 8'((i / 2) * 17) : 8'(255 - (i / 2) * 3);
      chk(byte_rdata == e, "R2", byte_rdata, e);
      chk(byte_rpar == op(e), "R4", byte_rpar, op(e));
      byte_rd = 1; tick();
    end
    byte_rd = 1; tick();
    chk(count == 0 && unf, "R10", {unf, count}, 6'h20);
    clr();
    chk(!ovf && !unf, "R9", {ovf, unf}, 0);

    // R6, R7, R1: request sweep over every fill level
    dir = 1;
    for (int c = 0; c <= 16; c++) begin
      for (int m = 0; m < 4; m++) begin
        dir = m[1]; burst = m[0]; #1;
        chk(int'(dma_req) == exp_req(c, dir, burst), burst ? "R6" : "R7", dma_req, exp_req(c, dir, burst));
      end
      dir = 1;
      if (c < 16) put_byte(8'(c * 13 + 7), op(8'(c * 13 + 7)));
    end
    chk(count == 16, "R1", count, 16);
    put_byte(8'h55, op(8'h55));
    chk(count == 16 && ovf, "R9", {ovf, count}, {1'b1, 5'd16});
    clr();

    // R3: words come out lower byte first
    for (int i = 0; i < 8; i++) begin
      logic [7:0] a, b;
      a = 8'((2 * i) * 13 + 7); b = 8'((2 * i + 1) * 13 + 7);
      chk(dma_rdata == {b, a}, "R3", dma_rdata, {b, a});
      chk(dma_rpar == {op(b), op(a)}, "R4", dma_rpar, {op(b), op(a)});
      dma_rd = 1; tick();
    end
    chk(count == 0, "R3", count, 0);

    // R5: pass-through over all byte values with arbitrary parity
    par_chk = 0;
    for (int v = 0; v < 256; v += 2) begin
      logic pa, pb;
      pa = (v % 3) == 0; pb = (v % 5) != 0;
      put_byte(8'(v), pa);
      put_byte(8'(v + 1), pb);
      chk(dma_rdata == {8'(v + 1), 8'(v)} && dma_rpar == {pb, pa}, "R5", {dma_rpar, dma_rdata}, {pb, pa, 8'(v + 1), 8'(v)});
      dma_rd = 1; tick();
    end
    chk(!par_err, "R5", par_err, 0);

    // R4: generated parity over all byte values, then bad parity is sticky
    par_chk = 1; dir = 0;
    for (int v = 0; v < 256; v += 2) begin
      put_word({8'(v + 1), 8'(v)}, {op(8'(v + 1)), op(8'(v))});
      chk(byte_rdata == 8'(v) && byte_rpar == op(8'(v)), "R4", {byte_rpar, byte_rdata}, {op(8'(v)), 8'(v)});
      byte_rd = 1; tick();
      chk(byte_rdata == 8'(v + 1) && byte_rpar == op(8'(v + 1)), "R4", {byte_rpar, byte_rdata}, {op(8'(v + 1)), 8'(v + 1)});
      byte_rd = 1; tick();
    end
    chk(!par_err, "R4", par_err, 0);
    put_word(16'h0300, {op(8'h03), ~op(8'h00)});
    chk(par_err, "R4", par_err, 1);
    chk(byte_rpar == op(8'h00), "R4", byte_rpar, op(8'h00));
    tick(); tick();
    chk(par_err, "R4", par_err, 1);
    clr();
    chk(!par_err, "R4", par_err, 0);

    // R11: flush beats a simultaneous write
    dma_wdata = 16'h1234; dma_wpar = {op(8'h12), op(8'h34)}; dma_wr = 1; flush = 1; tick();
    chk(count == 0, "R11", count, 0);

    // R12: inactive-side strobes ignored
    put_word(16'hA5C3, {op(8'hA5), op(8'hC3)});
    byte_wdata = 8'h11; byte_wpar = op(8'h11); byte_wr = 1; tick();
    chk(count == 2, "R12", count, 2);
    dma_rd = 1; tick();
    chk(count == 2 && byte_rdata == 8'hC3, "R12", {count, byte_rdata}, {5'd2, 8'hC3});
    dir = 1;
    dma_wdata = 16'h7777; dma_wr = 1; tick();
    byte_rd = 1; tick();
    chk(count == 2 && dma_rdata == 16'hA5C3, "R12", {count, dma_rdata}, {5'd2, 16'hA5C3});
    flush = 1; tick();

    // R8, R10: residue drain after an odd number of bytes
    put_byte(8'h21, op(8'h21)); put_byte(8'h43, op(8'h43)); put_byte(8'h65, op(8'h65));
    dma_rd = 1; tick();
    chk(count == 1 && !dma_partial, "R8", {dma_partial, count}, 1);
    dma_rd = 1; tick();
    chk(count == 1 && unf, "R10", {unf, count}, 6'h21);
    clr();
    drain = 1; #1;
    chk(dma_partial && dma_rdata == 16'h0065 && dma_rpar == {1'b1, op(8'h65)}, "R8",
        {dma_partial, dma_rpar, dma_rdata}, {1'b1, 1'b1, op(8'h65), 16'h0065});
    dma_rd = 1; tick();
    chk(count == 0 && !unf, "R8", {unf, count}, 0);
    dir = 0; put_word(16'h9988, {op(8'h99), op(8'h88)});
    byte_rd = 1; tick();
    chk(count == 2, "R8", count, 2);
    dma_rd = 1; tick();
    chk(count == 0, "R8", count, 0);
    drain = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule